// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Unit

This block turns per-vector interrupt requests from device logic into memory-write messages. It holds a table of N vector entries, a pending-bit array and two function-level control bits. Each entry holds a 64-bit target address, a 32-bit payload and a per-vector mask. Software reaches the table and the pending array through a 32-bit register port that takes only aligned word accesses. The control bits are written through a separate control-byte port. A request on a vector whose effective mask is clear becomes one write message carrying that entry's address and payload. A request on a masked vector is held as a pending bit and is sent automatically once the mask clears.

The message leaves on a valid/ready port. Once `msg_valid` is raised, it stays high with `msg_addr` and `msg_data` unchanged until a cycle in which `msg_ready` is also high. The message is taken on that edge. At most one message is outstanding, and at least one idle cycle separates two messages. The request input has no back-pressure: a one-cycle `req_valid` pulse is always taken. While the output is stalled, requests are recorded as pending bits and drained later in ascending vector order.

Top module: `msgirq_vector_unit`

## Requirements
- R1: After reset, the unit is in the following state.
  - Enable and mask-all are clear, so the function is masked.
  - Every address and payload word reads 0.
  - Every vector-control word reads 1, because every per-vector mask is set.
  - All pending bits read 0.
  - `msg_valid` is low.
- R2: Entry v occupies byte offsets v*16 to v*16+15 of the register space, as four words:
  - +0 holds address bits 31:0.
  - +4 holds address bits 63:32.
  - +8 holds the payload.
  - +12 holds vector control, whose bit 0 is the per-vector mask. The other bits of vector control read 0.
  - Read data appears on `reg_rdata` in the cycle after `reg_rd` and holds until the next read.
- R3: A `ctrl_wr` loads the enable bit from `ctrl_wdata[7]` and the mask-all bit from `ctrl_wdata[6]`. The remaining `ctrl_wdata` bits are ignored.
  - `ctrl_rdata` shows enable at bit 15, mask-all at bit 14 and N-1 in bits 10:0.
  - The function is masked while enable is clear or mask-all is set.
- R4: A request on an in-use vector below N whose effective mask is clear produces exactly one message with that entry's address and payload. The effective mask is the per-vector mask OR the function mask. When the output is idle, `msg_valid` rises at the second clock edge after the request edge.
- R5: A request on an in-use vector whose effective mask is set only sets that vector's pending bit. Pending bit v is bit v mod 32 of the word at PBA_BASE + 4*(v div 32); this is the same as bit v mod 8 of byte v div 8 in little-endian order.
- R6: When a vector goes from masked to unmasked with its pending bit set, its message is sent and the pending bit clears. This holds whether the change comes from a vector-control write or from a control-byte write.
- R7: The following have no effect and produce no message:
  - requests for a vector index of N or above;
  - requests for a vector whose `vec_used` bit is low.
  - In addition, dropping a vector's `vec_used` bit clears its pending bit.
- R8: `msg_valid` holds, with stable `msg_addr` and `msg_data`, until `msg_ready` is seen. The cycle after a message is taken always has `msg_valid` low.
- R9: Pending vectors whose masks permit are sent lowest index first.
- R10: The following register-port writes are discarded without error:
  - writes to the pending region;
  - writes beyond the table;
  - writes at an address that is not word-aligned.
  - Reads beyond the table or beyond the pending array, and misaligned reads, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register-port write strobe |
| reg_rd | input | 1 | Register-port read strobe |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| ctrl_wr | input | 1 | Control-byte write strobe |
| ctrl_wdata | input | 8 | Control byte: bit 7 enable, bit 6 mask-all |
| ctrl_rdata | output | 16 | Message-control word readback |
| req_valid | input | 1 | Interrupt request pulse |
| req_vec | input | VEC_W | Vector index of the request |
| vec_used | input | N | Per-vector in-use flags from device logic |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Message accepted by the write port |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message payload |

## Verification
The assertions check the following properties on every cycle:
- the message port keeps its payload stable while it is stalled;
- the message port leaves an idle cycle after each accepted message;
- a message only starts while the function is enabled and not mask-all;
- no pending bit survives for a vector that was not in use.

Some properties can only be shown by the bench's scenarios against its behavioural model:
- which entry a message carries;
- the ascending drain order after a stall;
- the replay of held requests after a per-vector or function-level unmask;
- the register map, including its zero-reading holes;
- the ignored out-of-range and unused requests.

// File: rtl/mvu_pkg.sv
package mvu_pkg;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
    logic        mask;
  } vec_entry_t;

  typedef enum logic [1:0] {
    W_ADDR_LO = 2'd0,
    W_ADDR_HI = 2'd1,
    W_DATA    = 2'd2,
    W_VCTRL   = 2'd3
  } ent_word_e;

endpackage

// File: rtl/mvu_table.sv
module mvu_table
  import mvu_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_vec,
  input  logic [1:0]       wr_word,
  input  logic [31:0]      wdata,
  output vec_entry_t       ents [N]
);

  vec_entry_t ents_q [N];

  for (genvar v = 0; v < N; v++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        ents_q[v] <= '{addr: 64'd0, data: 32'd0, mask: 1'b1};
      end else if (wr_en && wr_vec == IDX_W'(v)) begin
        case (ent_word_e'(wr_word))
          W_ADDR_LO: ents_q[v].addr[31:0]  <= wdata;
          W_ADDR_HI: ents_q[v].addr[63:32] <= wdata;
          W_DATA:    ents_q[v].data        <= wdata;
          default:   ents_q[v].mask        <= wdata[0];
        endcase
      end
    end
    assign ents[v] = ents_q[v];
  end

endmodule

// File: rtl/mvu_pending.sv
module mvu_pending #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     set_bits,
  input  logic [N-1:0]     used,
  input  logic [N-1:0]     blocked,
  input  logic             take,
  output logic [N-1:0]     pend,
  output logic             grant_any,
  output logic [IDX_W-1:0] grant_idx
);

  logic [N-1:0] pend_q;
  logic [N-1:0] cand;
  logic [N-1:0] clr;

  assign cand = pend_q & ~blocked & used;

  // lowest index wins: scan downward, last hit overrides
  always_comb begin
    grant_any = 1'b0;
    grant_idx = '0;
    for (int v = N - 1; v >= 0; v--) begin
      if (cand[v]) begin
        grant_any = 1'b1;
        grant_idx = IDX_W'(v);
      end
    end
  end

  assign clr = (take && grant_any) ? (N'(1) << grant_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= ((pend_q & ~clr) | set_bits) & used;
  end

  assign pend = pend_q;

endmodule

// File: rtl/mvu_sender.sv
module mvu_sender (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [63:0] load_addr,
  input  logic [31:0] load_data,
  input  logic        msg_ready,
  output logic        msg_valid,
  output logic [63:0] msg_addr,
  output logic [31:0] msg_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (load) begin
      msg_valid <= 1'b1;
      msg_addr  <= load_addr;
      msg_data  <= load_data;
    end else if (msg_valid && msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/msgirq_vector_unit.sv
module msgirq_vector_unit
  import mvu_pkg::*;
#(
  parameter int                N        = 8,
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] PBA_BASE = 12'h800,
  localparam int               VEC_W    = $clog2(N) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ctrl_wr,
  input  logic [7:0]        ctrl_wdata,
  output logic [15:0]       ctrl_rdata,
  input  logic              req_valid,
  input  logic [VEC_W-1:0]  req_vec,
  input  logic [N-1:0]      vec_used,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [63:0]       msg_addr,
  output logic [31:0]       msg_data
);

  localparam int IDX_W     = (N > 1) ? $clog2(N) : 1;
  localparam int WI_W      = ADDR_W - 2;
  localparam int TAB_WORDS = N * 4;
  localparam int PBA_WORDS = ((N + 63) / 64) * 2;
  localparam int PEND_BITS = PBA_WORDS * 32;

  vec_entry_t       ents [N];
  logic             en_q, mall_q, func_mask;
  logic [N-1:0]     blocked, set_bits, pend_bits;
  logic             grant_any, take;
  logic [IDX_W-1:0] grant_idx;
  logic             aligned, in_table, in_pba;
  logic [WI_W-1:0]  word_idx, pba_idx;
  logic [IDX_W-1:0] tab_vec;
  logic [31:0]      rd_word;
  logic [PEND_BITS-1:0] pend_pad;
  logic             unused_ctrl_bits;

  assign unused_ctrl_bits = ^ctrl_wdata[5:0];

  // function-level control
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      mall_q <= 1'b0;
    end else if (ctrl_wr) begin
      en_q   <= ctrl_wdata[7];
      mall_q <= ctrl_wdata[6];
    end
  end

  assign func_mask  = !en_q || mall_q;
  assign ctrl_rdata = {en_q, mall_q, 3'b000, 11'(N - 1)};

  // register-port decode
  assign aligned  = (reg_addr[1:0] == 2'b00);
  assign word_idx = reg_addr[ADDR_W-1:2];
  assign in_table = aligned && (reg_addr < PBA_BASE) && (word_idx < WI_W'(TAB_WORDS));
  assign in_pba   = aligned && (reg_addr >= PBA_BASE);
  assign pba_idx  = word_idx - WI_W'(PBA_BASE >> 2);
  assign tab_vec  = word_idx[IDX_W+1:2];

  mvu_table #(.N(N), .IDX_W(IDX_W)) u_table (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (reg_wr && in_table),
    .wr_vec (tab_vec),
    .wr_word(word_idx[1:0]),
    .wdata  (reg_wdata),
    .ents   (ents)
  );

  // request decode and effective masks
  for (genvar v = 0; v < N; v++) begin : g_vec
    assign set_bits[v] = req_valid && (req_vec == VEC_W'(v));
    assign blocked[v]  = ents[v].mask | func_mask;
  end

  assign take = !msg_valid;

  mvu_pending #(.N(N), .IDX_W(IDX_W)) u_pending (
    .clk      (clk),
    .rst      (rst),
    .set_bits (set_bits),
    .used     (vec_used),
    .blocked  (blocked),
    .take     (take),
    .pend     (pend_bits),
    .grant_any(grant_any),
    .grant_idx(grant_idx)
  );

  mvu_sender u_sender (
    .clk      (clk),
    .rst      (rst),
    .load     (take && grant_any),
    .load_addr(ents[grant_idx].addr),
    .load_data(ents[grant_idx].data),
    .msg_ready(msg_ready),
    .msg_valid(msg_valid),
    .msg_addr (msg_addr),
    .msg_data (msg_data)
  );

  // read path
  assign pend_pad = PEND_BITS'(pend_bits);

  always_comb begin
    rd_word = '0;
    if (in_table) begin
      case (ent_word_e'(word_idx[1:0]))
        W_ADDR_LO: rd_word = ents[tab_vec].addr[31:0];
        W_ADDR_HI: rd_word = ents[tab_vec].addr[63:32];
        W_DATA:    rd_word = ents[tab_vec].data;
        default:   rd_word = {31'd0, ents[tab_vec].mask};
      endcase
    end else if (in_pba) begin
      for (int k = 0; k < PBA_WORDS; k++) begin
        if (pba_idx == WI_W'(k)) rd_word = pend_pad[k*32 +: 32];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_word;
  end

endmodule

// File: rtl/mvu_checker.sv
module mvu_checker #(
  parameter int N = 8
) (
  input logic        clk,
  input logic        rst,
  input logic        msg_valid,
  input logic        msg_ready,
  input logic [63:0] msg_addr,
  input logic [31:0] msg_data,
  input logic [15:0] ctrl_rdata,
  input logic [N-1:0] pend,
  input logic [N-1:0] vec_used
);

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data)); // R8

  AST_MSG_GAP: assert property (@(posedge clk) disable iff (rst)
    msg_valid && msg_ready |=> !msg_valid); // R8

  AST_SEND_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> $past(ctrl_rdata[15] && !ctrl_rdata[14])); // R4

  AST_PEND_USED: assert property (@(posedge clk) disable iff (rst)
    (pend & ~$past(vec_used)) == '0); // R7

endmodule

bind msgirq_vector_unit mvu_checker #(.N(N)) u_mvu_chk (
  .clk       (clk),
  .rst       (rst),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .msg_addr  (msg_addr),
  .msg_data  (msg_data),
  .ctrl_rdata(ctrl_rdata),
  .pend      (pend_bits),
  .vec_used  (vec_used)
);

// File: tb/msgirq_vector_unit_bench.sv
module msgirq_vector_unit_bench;

  localparam int N = 8;
  localparam int VEC_W = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ctrl_wr = 1'b0;
  logic [7:0]  ctrl_wdata = '0;
  logic [15:0] ctrl_rdata;
  logic        req_valid = 1'b0;
  logic [VEC_W-1:0] req_vec = '0;
  logic [N-1:0] vec_used = 8'h7F;
  logic        msg_valid, msg_ready = 1'b1;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  always #2.5 clk = ~clk;

  msgirq_vector_unit #(.N(N)) u_msgirq_vector_unit (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctrl_wr(ctrl_wr),
    .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata), .req_valid(req_valid),
    .req_vec(req_vec), .vec_used(vec_used), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit live = 1'b0;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [63:0] t_addr [N];
  logic [31:0] t_data [N];
  bit          t_mask [N];
  bit [N-1:0]  m_pend;
  bit          m_en, m_mall, m_valid;
  logic [63:0] m_addr;
  logic [31:0] m_data, m_rdata;

  function automatic logic [31:0] mread(logic [11:0] a);
    int w, pw;
    logic [31:0] r;
    r = '0;
    if (a[1:0] != 0) return r;
    w = int'(a) / 4;
    if (a < 12'h800) begin
      if (w < N * 4) begin
        case (w % 4)
          0: r = t_addr[w/4][31:0];
          1: r = t_addr[w/4][63:32];
          2: r = t_data[w/4];
          default: r = {31'd0, t_mask[w/4]};
        endcase
      end
    end else begin
      pw = (int'(a) - 'h800) / 4;
      for (int b = 0; b < 32; b++)
        if (pw * 32 + b < N) r[b] = m_pend[pw*32+b];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int v = 0; v < N; v++) begin
        t_addr[v] = '0; t_data[v] = '0; t_mask[v] = 1'b1;
      end
      m_pend = '0; m_en = 0; m_mall = 0; m_valid = 0;
      m_addr = '0; m_data = '0; m_rdata = '0;
    end else begin
      bit fm, found;
      logic [31:0] rd;
      rd = mread(reg_addr);
      fm = !m_en || m_mall;
      found = 0;
      if (!m_valid) begin
        for (int v = 0; v < N; v++) begin
          if (!found && m_pend[v] && !(t_mask[v] || fm) && vec_used[v]) begin
            found = 1; m_valid = 1; m_addr = t_addr[v]; m_data = t_data[v];
            m_pend[v] = 0;
          end
        end
      end else if (msg_ready) begin
        m_valid = 0;
      end
      if (req_valid && req_vec < N) m_pend[req_vec[2:0]] = 1;
      m_pend &= vec_used;
      if (reg_rd) m_rdata = rd;
      if (reg_wr && reg_addr[1:0] == 0 && reg_addr < 12'h800 && int'(reg_addr) / 4 < N * 4) begin
        int w;
        w = int'(reg_addr) / 4;
        case (w % 4)
          0: t_addr[w/4][31:0] = reg_wdata;
          1: t_addr[w/4][63:32] = reg_wdata;
          2: t_data[w/4] = reg_wdata;
          default: t_mask[w/4] = reg_wdata[0];
        endcase
      end
      if (ctrl_wr) begin m_en = ctrl_wdata[7]; m_mall = ctrl_wdata[6]; end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (live && !rst) begin
      chk(msg_valid == m_valid, "R8 model msg_valid", 64'(msg_valid), 64'(m_valid));
      if (m_valid) begin
        chk(msg_addr == m_addr, "R4 model msg_addr", msg_addr, m_addr);
        chk(msg_data == m_data, "R4 model msg_data", 64'(msg_data), 64'(m_data));
      end
      chk(reg_rdata == m_rdata, "R2 model reg_rdata", 64'(reg_rdata), 64'(m_rdata));
      chk(ctrl_rdata == {m_en, m_mall, 3'b000, 11'(N - 1)}, "R3 model ctrl_rdata",
          64'(ctrl_rdata), 64'({m_en, m_mall, 3'b000, 11'(N - 1)}));
    end
  end

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
      finish_up();
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic reg_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic reg_read(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0;
    chk(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic ctrl_write(logic [7:0] b);
    @(negedge clk); ctrl_wr = 1; ctrl_wdata = b;
    @(negedge clk); ctrl_wr = 0;
  endtask

  task automatic request(int v);
    @(negedge clk); req_valid = 1; req_vec = VEC_W'(v);
    @(negedge clk); req_valid = 0;
  endtask

  task automatic wait_msg(logic [63:0] a, logic [31:0] d, string tag);
    int k = 0;
    while (!msg_valid && k < 12) begin @(negedge clk); k++; end
    chk(msg_valid, tag, 64'(msg_valid), 64'd1);
    chk(msg_addr == a, tag, msg_addr, a);
    chk(msg_data == d, tag, 64'(msg_data), 64'(d));
    @(negedge clk);
  endtask

  task automatic quiet(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!msg_valid, tag, 64'(msg_valid), 64'd0);
    end
  endtask

  localparam logic [63:0] A2 = 64'h0000_0001_0000_2000, A3 = 64'h0000_0000_3000_0300,
                          A5 = 64'h0000_000A_5000_0050;
  localparam logic [31:0] D2 = 32'h0000_00D2, D3 = 32'h0000_00D3, D5 = 32'h0000_00D5;

  initial begin
    repeat (4) @(negedge clk);
    rst = 0; live = 1;
    @(negedge clk);
    // R1 reset state
    chk(ctrl_rdata == 16'h0007, "R1 ctrl after reset", 64'(ctrl_rdata), 64'h7);
    chk(!msg_valid, "R1 no message after reset", 64'(msg_valid), 0);
    reg_read(12'h00C, 32'h1, "R1 vector mask set");
    reg_read(12'h010, 32'h0, "R1 address zeroed");
    reg_read(12'h800, 32'h0, "R1 pending zeroed");

    // R2 table layout
    reg_write(12'h020, A2[31:0]); reg_write(12'h024, A2[63:32]); reg_write(12'h028, D2);
    reg_write(12'h030, A3[31:0]); reg_write(12'h034, A3[63:32]); reg_write(12'h038, D3);
    reg_write(12'h050, A5[31:0]); reg_write(12'h054, A5[63:32]); reg_write(12'h058, D5);
    reg_read(12'h050, A5[31:0], "R2 addr low word");
    reg_read(12'h054, A5[63:32], "R2 addr high word");
    reg_read(12'h058, D5, "R2 payload word");
    reg_write(12'h05C, 32'hFFFF_FFFE);
    reg_read(12'h05C, 32'h0, "R2 vector control only bit0");
    reg_write(12'h05C, 32'h1);

    // R5 request while function disabled
    request(2);
    quiet(3, "R5 masked request sends nothing");
    reg_read(12'h800, 32'h04, "R5 pending bit 2");
    reg_write(12'h02C, 32'h0);
    quiet(2, "R6 still function-masked");
    reg_read(12'h800, 32'h04, "R5 pending kept");

    // R6 enable releases pending
    ctrl_write(8'h80);
    chk(ctrl_rdata == 16'h8007, "R3 enable readback", 64'(ctrl_rdata), 64'h8007);
    wait_msg(A2, D2, "R6 replay on function unmask");
    reg_read(12'h800, 32'h0, "R6 pending cleared");

    // R4 latency of an unmasked request
    request(2);
    chk(!msg_valid, "R4 one edge after request", 64'(msg_valid), 0);
    @(negedge clk);
    chk(msg_valid && msg_addr == A2 && msg_data == D2, "R4 message two edges after request",
        {msg_addr[31:0], msg_data}, {A2[31:0], D2});
    @(negedge clk);

    // R5 per-vector mask then R6 via table write
    request(6);
    reg_read(12'h800, 32'h40, "R5 per-vector masked pending");
    reg_write(12'h06C, 32'h0);
    wait_msg(64'h0, 32'h0, "R6 replay on vector unmask");

    // R8 / R9 back-pressure and ordering
    reg_write(12'h03C, 32'h0); reg_write(12'h05C, 32'h0);
    msg_ready = 0;
    request(5); request(3); request(2);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(msg_valid && msg_addr == A5, "R8 held under back-pressure", msg_addr, A5);
    end
    reg_read(12'h800, 32'h0C, "R9 stalled requests pending");
    msg_ready = 1;
    wait_msg(A5, D5, "R8 first message");
    wait_msg(A2, D2, "R9 lowest pending next");
    wait_msg(A3, D3, "R9 then higher");

    // R7 ignored requests
    request(8); request(15); request(7);
    quiet(3, "R7 ignored request");
    reg_read(12'h800, 32'h0, "R7 no pending from ignored");
    ctrl_write(8'hFF);
    chk(ctrl_rdata == 16'hC007, "R3 mask-all readback", 64'(ctrl_rdata), 64'hC007);
    request(4); request(2);
    reg_read(12'h800, 32'h14, "R5 function-masked pending");
    @(negedge clk); vec_used = 8'h6F;
    @(negedge clk); vec_used = 8'h7F;
    reg_read(12'h800, 32'h04, "R7 unused clears pending");

    // R6 via clearing mask-all
    ctrl_write(8'h80);
    wait_msg(A2, D2, "R6 replay on mask-all clear");

    // R10 discarded writes and zero reads
    request(6); // v6 unmasked earlier -> message
    wait_msg(64'h0, 32'h0, "R4 vector 6 message");
    reg_write(12'h800, 32'hFFFF_FFFF);
    reg_read(12'h800, 32'h0, "R10 pending write discarded");
    reg_read(12'h804, 32'h0, "R10 upper pending word");
    reg_read(12'h808, 32'h0, "R10 beyond pending");
    reg_write(12'h080, 32'h1234_5678);
    reg_read(12'h080, 32'h0, "R10 beyond table");
    reg_write(12'h022, 32'hDEAD_BEEF);
    reg_read(12'h020, A2[31:0], "R10 misaligned write dropped");
    reg_read(12'h022, 32'h0, "R10 misaligned read zero");

    repeat (3) @(negedge clk);
    finish_up();
  end

endmodule